// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block turns the logic-level commands for one or more half-bridge legs into a high-side and a low-side gate enable per leg. Each leg takes an active-low shutdown, a direction-style select and a PWM line. The high switch is enabled only when direction and PWM are both high. Every other combination enables the low switch, so the low switch is the resting state. Whenever the active switch changes, both enables are held off for a programmable number of clock cycles before the other switch is enabled. This gap lets one gate discharge before the other charges.

Two undervoltage flags per leg gate the outputs. They come from comparators elsewhere, already digitised, synchronous to the clock and with hysteresis applied. A driver-supply fault removes both enables. A fault on the floating high-side supply removes only the high enable. After the floating supply recovers, the high switch stays off until a fresh edge arrives on direction or PWM. The block also gives each leg an enable for its protection comparator, which is withdrawn while the driver supply is low. Each leg has its own flags, dead-time setting and state, so a fault on one leg leaves the others running.

Top module: `hb_gate_seq`

## Requirements
- R1: With the synchronised shutdown input of a leg low, both enables of that leg are 0 from the next cycle on, whatever direction and PWM do.
- R2: With shutdown high and no undervoltage, the requested state is high-side when the synchronised direction and PWM are both 1 and the leg is armed. In every other case the requested state is low-side.
- R3: The high-side and low-side enables of a leg are never 1 in the same cycle.
- R4: A leg enables a switch only after both of its enables have been 0 for D consecutive cycles with an unchanged request. D is the leg's dead-time field, and the gap is exactly D cycles when the request is steady.
- R5: If the request changes while a leg is in its off gap, the count starts again from zero for the new request.
- R6: A dead-time field of 0 behaves as D = 1, so at least one all-off cycle separates the two switches.
- R7: A driver-supply undervoltage flag of 1 forces both enables of that leg to 0 in the next cycle. Once the flag returns to 0, the leg follows the current input levels after the dead time, without needing an input edge.
- R8: A floating-supply undervoltage flag of 1 forces the leg's high enable to 0 in the next cycle and clears its arm state; the low side then takes over. After the flag clears, the high side turns on only after a change of the synchronised direction or PWM value re-arms the leg.
- R9: The comparator enable of a leg is the inverse of its driver-supply undervoltage flag, delayed by one register stage.
- R10: Shutdown, undervoltage and dead time of one leg have no effect on any other leg's outputs.
- R11: During and directly after reset, all enables and comparator enables are 0, and every leg starts disarmed.
- R12: Shutdown, direction and PWM pass through SYNC_STAGES flops before they are decoded. A change therefore leaves the enables untouched for SYNC_STAGES cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| leg_shdn_n | input | NB | Per-leg shutdown, active low, asynchronous |
| leg_dir | input | NB | Per-leg direction select, asynchronous |
| leg_pwm | input | NB | Per-leg PWM command, asynchronous |
| drv_uv | input | NB | Per-leg driver-supply undervoltage flag, synchronous |
| boot_uv | input | NB | Per-leg floating-supply undervoltage flag, synchronous |
| dead_cycles | input | NB*DT_W | Per-leg dead time in clock cycles; leg b in bits [b*DT_W +: DT_W] |
| hs_en | output | NB | Per-leg high-side gate enable |
| ls_en | output | NB | Per-leg low-side gate enable |
| cmp_en | output | NB | Per-leg protection comparator enable |

## Verification
The bench builds the block with NB = 2, DT_W = 10, SYNC_STAGES = 2 and the registered comparator-enable variant. Having two legs lets faults and shutdown on one leg be checked against the steady outputs of the other. The 10-bit field allows dead times of 0, 1, 3, 6, 7 and 40 cycles. Over the random phase, fields between 0 and 9 reach the zero clamp, gaps that restart mid-count and long gaps measured at the ports. A short two-stage synchroniser keeps the input latency small, so the bench can exercise the re-arm rule and fast PWM toggling within a few cycles.

// File: rtl/hb_pkg.sv
package hb_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // Leg output state; also used as the decoded request
   typedef enum logic [1:0] {
      LEG_OFF = 2'd0,
      LEG_LO  = 2'd1,
      LEG_HI  = 2'd2
   } leg_t;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   timeunit 1ns;
   timeprecision 1ps;

   if (STAGES < 2) begin : g_bad_stages
      $error("hb_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hb_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/hb_arm.sv
module hb_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic s_dir,
   input  logic s_pwm,
   input  logic boot_uv,
   output logic armed
);
   timeunit 1ns;
   timeprecision 1ps;

   logic dir_q, pwm_q;
   logic edge_seen;

   // any change of the synchronised command lines counts as a fresh edge
   assign edge_seen = (s_dir ^ dir_q) | (s_pwm ^ pwm_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= 1'b0;
         pwm_q <= 1'b0;
         armed <= 1'b0;
      end else begin
         dir_q <= s_dir;
         pwm_q <= s_pwm;
         armed <= !boot_uv && (armed || edge_seen);
      end
   end
endmodule

// File: rtl/hb_dtseq.sv
module hb_dtseq
   import hb_pkg::*;
#(
   parameter int DT_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  leg_t            req,
   input  logic [DT_W-1:0] dead_cyc,
   output logic            hs,
   output logic            ls
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int              CW  = DT_W + 1;
   localparam logic [DT_W-1:0] ONE = DT_W'(1);

   if (DT_W < 1) begin : g_bad_dtw
      $error("hb_dtseq: DT_W must be at least 1");
   end

   leg_t            st_q, tgt_q;
   logic [DT_W-1:0] cnt_q;
   logic [DT_W-1:0] dt_eff;
   logic [CW-1:0]   cnt_nx;

   assign dt_eff = (dead_cyc == '0) ? ONE : dead_cyc;
   assign cnt_nx = {1'b0, cnt_q} + CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= LEG_OFF;
         tgt_q <= LEG_OFF;
         cnt_q <= '0;
      end else begin
         case (st_q)
            LEG_OFF: begin
               if (req == LEG_OFF || req != tgt_q) begin
                  tgt_q <= req;
                  cnt_q <= '0;
               end else if (cnt_nx >= {1'b0, dt_eff}) begin
                  st_q  <= req;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_nx[DT_W-1:0];
               end
            end
            default: begin
               if (req != st_q) begin
                  st_q  <= LEG_OFF;
                  tgt_q <= req;
                  cnt_q <= '0;
               end
            end
         endcase
      end
   end

   assign hs = (st_q == LEG_HI);
   assign ls = (st_q == LEG_LO);

   // ---- gap observer for the dead-time properties ----
   logic [CW-1:0]   gap_q;
   logic            moved_q;
   logic [DT_W-1:0] dtp_q;
   logic [DT_W-1:0] dtp_eff;

   assign dtp_eff = (dtp_q == '0) ? ONE : dtp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q   <= '0;
         moved_q <= 1'b0;
         dtp_q   <= '0;
      end else begin
         dtp_q <= dead_cyc;
         if (hs || ls) begin
            gap_q   <= '0;
            moved_q <= 1'b0;
         end else begin
            if (gap_q != {CW{1'b1}}) gap_q <= gap_q + CW'(1);
            if (dead_cyc != dtp_q) moved_q <= 1'b1;
         end
      end
   end

   // R3
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs && ls));

   // R6
   gap_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hs) || $rose(ls)) |-> $past(!hs && !ls));

   // R4
   gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($rose(hs) || $rose(ls)) && !moved_q) |-> (gap_q >= {1'b0, dtp_eff}));
endmodule

// File: rtl/hb_leg.sv
module hb_leg
   import hb_pkg::*;
#(
   parameter int DT_W        = 10,
   parameter int SYNC_STAGES = 2,
   parameter int CMP_REG     = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shdn_n,
   input  logic            dir,
   input  logic            pwm,
   input  logic            drv_uv,
   input  logic            boot_uv,
   input  logic [DT_W-1:0] dead_cyc,
   output logic            hs_en,
   output logic            ls_en,
   output logic            cmp_en
);
   timeunit 1ns;
   timeprecision 1ps;

   if (CMP_REG != 0 && CMP_REG != 1) begin : g_bad_cmp
      $error("hb_leg: CMP_REG must be 0 or 1");
   end

   logic [2:0] raw, syn;
   logic       s_shdn, s_dir, s_pwm;
   logic       armed;
   leg_t       req;

   assign raw = {shdn_n, dir, pwm};

   hb_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   assign s_shdn = syn[2];
   assign s_dir  = syn[1];
   assign s_pwm  = syn[0];

   hb_arm u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .s_dir   (s_dir),
      .s_pwm   (s_pwm),
      .boot_uv (boot_uv),
      .armed   (armed)
   );

   always_comb begin
      if (!s_shdn || drv_uv)                         req = LEG_OFF;
      else if (s_dir && s_pwm && armed && !boot_uv)  req = LEG_HI;
      else                                           req = LEG_LO;
   end

   hb_dtseq #(.DT_W(DT_W)) u_dt (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .dead_cyc (dead_cyc),
      .hs       (hs_en),
      .ls       (ls_en)
   );

   if (CMP_REG == 1) begin : g_cmp_reg
      logic cmp_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cmp_q <= 1'b0;
         else        cmp_q <= !drv_uv;
      end
      assign cmp_en = cmp_q;

      // R9
      cmp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         drv_uv |=> !cmp_en);
   end else begin : g_cmp_comb
      assign cmp_en = !drv_uv;
   end

   // R1
   shdn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s_shdn |=> (!hs_en && !ls_en));

   // R7
   drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_uv |=> (!hs_en && !ls_en));

   // R8
   boot_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_uv |=> !hs_en);

   // R8
   arm_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> $past(armed));
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
   parameter int NB          = 2,
   parameter int DT_W        = 10,
   parameter int SYNC_STAGES = 2,
   parameter int CMP_REG     = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NB-1:0]    leg_shdn_n,
   input  logic [NB-1:0]    leg_dir,
   input  logic [NB-1:0]    leg_pwm,
   input  logic [NB-1:0]    drv_uv,
   input  logic [NB-1:0]    boot_uv,
   input  logic [NB*DT_W-1:0] dead_cycles,
   output logic [NB-1:0]    hs_en,
   output logic [NB-1:0]    ls_en,
   output logic [NB-1:0]    cmp_en
);
   timeunit 1ns;
   timeprecision 1ps;

   if (NB < 1) begin : g_bad_nb
      $error("hb_gate_seq: NB must be at least 1");
   end

   for (genvar b = 0; b < NB; b++) begin : g_leg
      hb_leg #(
         .DT_W        (DT_W),
         .SYNC_STAGES (SYNC_STAGES),
         .CMP_REG     (CMP_REG)
      ) u_leg (
         .clk      (clk),
         .rst_n    (rst_n),
         .shdn_n   (leg_shdn_n[b]),
         .dir      (leg_dir[b]),
         .pwm      (leg_pwm[b]),
         .drv_uv   (drv_uv[b]),
         .boot_uv  (boot_uv[b]),
         .dead_cyc (dead_cycles[b*DT_W +: DT_W]),
         .hs_en    (hs_en[b]),
         .ls_en    (ls_en[b]),
         .cmp_en   (cmp_en[b])
      );
   end
endmodule

// File: tb/sim_hb_gate_seq.sv
module sim_hb_gate_seq;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NB   = 2;
   localparam int DT_W = 10;
   localparam int SS   = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NB-1:0]    leg_shdn_n = '0;
   logic [NB-1:0]    leg_dir = '0;
   logic [NB-1:0]    leg_pwm = '0;
   logic [NB-1:0]    drv_uv = '0;
   logic [NB-1:0]    boot_uv = '0;
   logic [NB*DT_W-1:0] dead_cycles = '0;
   logic [NB-1:0]    hs_en, ls_en, cmp_en;

   int    checks = 0;
   int    errors = 0;
   bit    done = 0;
   string tag = "R11";

   always #2 clk = ~clk;

   hb_gate_seq #(.NB(NB), .DT_W(DT_W), .SYNC_STAGES(SS), .CMP_REG(1)) u0 (
      .clk(clk), .rst_n(rst_n), .leg_shdn_n(leg_shdn_n), .leg_dir(leg_dir),
      .leg_pwm(leg_pwm), .drv_uv(drv_uv), .boot_uv(boot_uv),
      .dead_cycles(dead_cycles), .hs_en(hs_en), .ls_en(ls_en), .cmp_en(cmp_en)
   );

   // ---- behavioural reference, advanced on every rising edge ----
   bit [SS-1:0] p_sh [NB];
   bit [SS-1:0] p_di [NB];
   bit [SS-1:0] p_pw [NB];
   bit m_pd [NB], m_pp [NB], m_arm [NB], m_cmp [NB];
   int m_st [NB], m_tgt [NB], m_cnt [NB];   // 0 off, 1 low, 2 high

   initial begin
      for (int b = 0; b < NB; b++) begin
         p_sh[b] = '0; p_di[b] = '0; p_pw[b] = '0;
         m_pd[b] = 0; m_pp[b] = 0; m_arm[b] = 0; m_cmp[b] = 0;
         m_st[b] = 0; m_tgt[b] = 0; m_cnt[b] = 0;
      end
   end

   always @(posedge clk) begin
      for (int b = 0; b < NB; b++) begin
         if (!rst_n) begin
            p_sh[b] = '0; p_di[b] = '0; p_pw[b] = '0;
            m_pd[b] = 0; m_pp[b] = 0; m_arm[b] = 0; m_cmp[b] = 0;
            m_st[b] = 0; m_tgt[b] = 0; m_cnt[b] = 0;
         end else begin
            bit sh, di, pw, edg;
            int rq, eff;
            sh  = p_sh[b][SS-1];
            di  = p_di[b][SS-1];
            pw  = p_pw[b][SS-1];
            eff = int'(dead_cycles[b*DT_W +: DT_W]);
            if (eff == 0) eff = 1;
            if (!sh || drv_uv[b])                          rq = 0;
            else if (di && pw && m_arm[b] && !boot_uv[b])  rq = 2;
            else                                           rq = 1;
            edg = (di != m_pd[b]) || (pw != m_pp[b]);
            m_arm[b] = !boot_uv[b] && (m_arm[b] || edg);
            if (m_st[b] == 0) begin
               if (rq == 0 || rq != m_tgt[b]) begin
                  m_tgt[b] = rq; m_cnt[b] = 0;
               end else if (m_cnt[b] + 1 >= eff) begin
                  m_st[b] = rq; m_cnt[b] = 0;
               end else begin
                  m_cnt[b]++;
               end
            end else if (rq != m_st[b]) begin
               m_st[b] = 0; m_tgt[b] = rq; m_cnt[b] = 0;
            end
            m_pd[b] = di;
            m_pp[b] = pw;
            p_sh[b] = {p_sh[b][SS-2:0], leg_shdn_n[b]};
            p_di[b] = {p_di[b][SS-2:0], leg_dir[b]};
            p_pw[b] = {p_pw[b][SS-2:0], leg_pwm[b]};
            m_cmp[b] = !drv_uv[b];
         end
      end
   end

   // ---- per-cycle comparison, away from the rising edge ----
   always @(negedge clk) begin
      if (!done) begin
         for (int b = 0; b < NB; b++) begin
            bit eh, el;
            eh = (m_st[b] == 2);
            el = (m_st[b] == 1);
            checks++;
            if (hs_en[b] !== eh || ls_en[b] !== el || cmp_en[b] !== m_cmp[b]) begin
               errors++;
               $display("FAIL %s leg %0d hs/ls/cmp actual %b%b%b expected %b%b%b at %0t",
                        tag, b, hs_en[b], ls_en[b], cmp_en[b], eh, el, m_cmp[b], $time);
            end
            // R3: never both enables together
            checks++;
            if (hs_en[b] === 1'b1 && ls_en[b] === 1'b1) begin
               errors++;
               $display("FAIL R3 leg %0d actual hs=1 ls=1 expected not both", b);
            end
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spot(input string r, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", r, got, exp, $time);
      end
   endtask

   task automatic set_dt(input int b, input int v);
      dead_cycles[b*DT_W +: DT_W] = DT_W'(v);
   endtask

   // wait for leg 0 to go all-off, then count the all-off cycles
   task automatic measure(output int gap);
      int k;
      k = 0;
      gap = 0;
      while ((hs_en[0] || ls_en[0]) && k < 100) begin
         @(negedge clk); k++;
      end
      while (!hs_en[0] && !ls_en[0] && gap < 300) begin
         gap++; @(negedge clk);
      end
   endtask

   initial begin
      int g;
      logic [31:0] lf;
      lf = 32'h1ACE_5EED;
      set_dt(0, 3);
      set_dt(1, 5);
      step(3);
      // R11 reset state
      spot("R11", int'(hs_en[0]), 0);
      spot("R11", int'(ls_en[0]), 0);
      spot("R11", int'(cmp_en[0]), 0);
      rst_n = 1'b1;

      tag = "R2";
      leg_shdn_n = 2'b11;
      step(15);
      spot("R2", int'(ls_en[0]), 1);
      spot("R2", int'(hs_en[0]), 0);
      leg_dir[0] = 1'b1;
      step(15);
      spot("R2", int'(ls_en[0]), 1);
      leg_pwm[0] = 1'b1;
      step(15);
      spot("R2", int'(hs_en[0]), 1);
      spot("R10", int'(ls_en[1]), 1);

      tag = "R4";
      leg_pwm[0] = 1'b0;
      step(15);
      spot("R4", int'(ls_en[0]), 1);
      leg_pwm[0] = 1'b1;
      measure(g);
      spot("R4", g, 3);
      set_dt(0, 7);
      step(5);
      leg_pwm[0] = 1'b0;
      measure(g);
      spot("R4", g, 7);

      tag = "R6";
      set_dt(0, 0);
      step(5);
      leg_pwm[0] = 1'b1;
      measure(g);
      spot("R6", g, 1);

      tag = "R5";
      set_dt(0, 6);
      step(5);
      leg_pwm[0] = 1'b0;
      begin
         int k;
         k = 0;
         g = 0;
         while (hs_en[0] && k < 100) begin @(negedge clk); k++; end
         while (!hs_en[0] && !ls_en[0] && g < 300) begin
            g++;
            if (g == 2) leg_pwm[0] = 1'b1;
            @(negedge clk);
         end
      end
      spot("R5", g, 10);
      spot("R5", int'(hs_en[0]), 1);

      tag = "R7";
      set_dt(0, 3);
      step(5);
      drv_uv[0] = 1'b1;
      step(1);
      spot("R7", int'(hs_en[0] | ls_en[0]), 0);
      spot("R9", int'(cmp_en[0]), 0);
      spot("R10", int'(ls_en[1]), 1);
      spot("R10", int'(cmp_en[1]), 1);
      step(10);
      drv_uv[0] = 1'b0;
      step(12);
      spot("R7", int'(hs_en[0]), 1);
      spot("R9", int'(cmp_en[0]), 1);

      tag = "R8";
      boot_uv[0] = 1'b1;
      step(1);
      spot("R8", int'(hs_en[0]), 0);
      step(15);
      spot("R8", int'(ls_en[0]), 1);
      boot_uv[0] = 1'b0;
      step(30);
      spot("R8", int'(hs_en[0]), 0);
      spot("R8", int'(ls_en[0]), 1);
      leg_pwm[0] = 1'b0;
      step(3);
      leg_pwm[0] = 1'b1;
      step(15);
      spot("R8", int'(hs_en[0]), 1);

      tag = "R1";
      leg_shdn_n[0] = 1'b0;
      step(2);
      spot("R12", int'(hs_en[0]), 1);
      step(1);
      spot("R1", int'(hs_en[0] | ls_en[0]), 0);
      spot("R10", int'(ls_en[1]), 1);
      leg_dir[0] = 1'b0;
      step(10);
      spot("R1", int'(hs_en[0] | ls_en[0]), 0);
      leg_dir[0] = 1'b1;
      leg_shdn_n[0] = 1'b1;
      step(20);
      spot("R1", int'(hs_en[0]), 1);

      tag = "R4";
      set_dt(0, 40);
      step(3);
      leg_pwm[0] = 1'b0;
      measure(g);
      spot("R4", g, 40);

      tag = "R2";
      for (int i = 0; i < 3000; i++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         for (int b = 0; b < NB; b++) begin
            if (lf[b*4 +: 3] == 3'd0) leg_pwm[b] = ~leg_pwm[b];
            if (lf[b*4 + 8 +: 4] == 4'd0) leg_dir[b] = ~leg_dir[b];
            if (lf[b*5 + 12 +: 5] == 5'd1) leg_shdn_n[b] = ~leg_shdn_n[b];
            if (lf[b*5 + 20 +: 6] == 6'd2) drv_uv[b] = ~drv_uv[b];
            if (lf[b*3 + 17 +: 6] == 6'd3) boot_uv[b] = ~boot_uv[b];
            if (lf[b*7 +: 7] == 7'd5) set_dt(b, int'(lf[27:24]) % 10);
         end
         step(1);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule